// File: doc/BRIEF.md
# Card Bus Cycle Phase Timer

This block runs one access on a peripheral-card bus as a fixed sequence of three timed phases: address setup, command strobe and recovery. Each phase length is counted in internal clock cycles. It comes from a dedicated timing byte that holds a prescaler selection and a multiplier. The phase length is the prescaler times the multiplier, plus one clock.

A host logic block raises `start` with a read/write flag while the timer is idle. The timer raises `busy` for the whole access and drives the active-low `cmd_n` strobe only during the command phase. It pulses `done` on the final recovery clock. The three timing bytes are written through a small byte-wide register port. The phase lengths are captured when an access is accepted, so a write during an access only affects later accesses.

Top module: `card_cycle_timer`

## Requirements
- R1: The setup phase lasts exactly S = (P × V) + 1 clocks, where P and V come from the setup timing byte. During setup `busy` is 1 and `cmd_n` is 1.
- R2: The command phase follows setup directly. `cmd_n` is 0 for exactly C = (P × V) + 1 clocks, taken from the command timing byte.
- R3: The recovery phase follows command directly. It lasts exactly R = (P × V) + 1 clocks from the recovery timing byte, with `cmd_n` at 1.
- R4: In a timing byte, bits [5:0] hold V. Bits [7:6] select P: 00 selects 1, 01 selects 16, 10 selects 64 and 11 selects 256. V = 0 gives a one-clock phase.
- R5: A write with `reg_we` = 1 loads the setup byte at address 3Ah, the command byte at 3Bh and the recovery byte at 3Ch. A write to any other address changes none of them.
- R6: Reset brings the timer idle (`busy` = 0, `cmd_n` = 1, `done` = 0). Reset also loads the bytes 01h, 06h and 03h, so an access after reset has phases of 2, 7 and 4 clocks.
- R7: Phases always run in the order setup, command, recovery. `cmd_n` is never 0 outside the command phase, and it never falls a second time within one access.
- R8: `done` is 1 for exactly one clock, the last recovery clock. `busy` is 0 on the following clock.
- R9: `start` is sampled only while `busy` is 0. `busy` is 1 on the clock after acceptance. A `start` seen during an access, including on its `done` clock, is ignored, so held `start` leaves at least one idle clock between accesses.
- R10: A timing byte written while an access is in progress does not change any phase of that access. It applies from the next accepted access.
- R11: `cyc_write` equals the `start_write` value captured at acceptance and holds steady for the whole access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock; all phase counts are in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Access request, sampled while idle |
| start_write | input | 1 | 1 for a write access, 0 for a read, sampled with `start` |
| reg_we | input | 1 | Timing register write enable |
| reg_addr | input | 8 | Timing register index |
| reg_wdata | input | 8 | Timing byte to write |
| busy | output | 1 | High for every clock of an access |
| cmd_n | output | 1 | Active-low command strobe |
| done | output | 1 | One-clock pulse on the last recovery clock |
| cyc_write | output | 1 | Direction of the current access |

## Verification
The access is first run with the reset bytes, which gives the 2/7/4 pattern. It is then run with bytes that use each of the four prescaler codes, a zero multiplier and the full 256 × 63 span. These show whether the field split and the scale per code are right, and whether the +1 clock is present. A strobe of one clock sits between other phases, and a recovery of one clock ends an access, so both probe the counter boundaries. Held and repeated `start` pulses show whether a request is wrongly taken mid-access or on the done clock. Writes during an access, and writes to neighbouring indices, show whether captured lengths are isolated from the register file.

// File: rtl/cct_pkg.sv
package cct_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_CMD   = 2'd2,
      PH_REC   = 2'd3
   } phase_t;

   // number of timed phases per access, in run order setup/command/recovery
   localparam int NUM_PHASES = 3;

   // largest prescaler shift (256 = 1 << 8)
   localparam int MAX_SHIFT = 8;

   // prescaler code to shift amount: 00->x1, 01->x16, 10->x64, 11->x256
   function automatic logic [3:0] pres_shift(input logic [1:0] sel);
      case (sel)
         2'b00:   pres_shift = 4'd0;
         2'b01:   pres_shift = 4'd4;
         2'b10:   pres_shift = 4'd6;
         default: pres_shift = 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/cct_regs.sv
module cct_regs #(
   parameter int                     ADDR_W   = 8,
   parameter int                     DATA_W   = 8,
   parameter int                     NUM_REGS = 3,
   parameter logic [ADDR_W-1:0]      BASE_IDX = 8'h3A,
   parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = '0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reg_we,
   input  logic [ADDR_W-1:0]            reg_addr,
   input  logic [DATA_W-1:0]            reg_wdata,
   output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);

   logic [NUM_REGS-1:0] hit;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [ADDR_W-1:0] MY_IDX = BASE_IDX + ADDR_W'(i);
      logic [DATA_W-1:0] q;

      assign hit[i] = reg_we && (reg_addr == MY_IDX);

      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= DEFAULTS[i*DATA_W +: DATA_W];
         else if (hit[i])
            q <= reg_wdata;
      end

      assign regs_flat[i*DATA_W +: DATA_W] = q;
   end

   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && (hit == '0)) |=> $stable(regs_flat)) else $error("stray write"); // R5

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)) else $error("multiple targets"); // R5

endmodule

// File: rtl/cct_len_calc.sv
module cct_len_calc
   import cct_pkg::*;
#(
   parameter int VAL_W = 6,
   parameter int SEL_W = 2,
   parameter int CNT_W = VAL_W + MAX_SHIFT,
   localparam int DATA_W = VAL_W + SEL_W
) (
   input  logic [DATA_W-1:0] tbyte,
   output logic [CNT_W-1:0]  len
);

   logic [VAL_W-1:0] mult;
   logic [SEL_W-1:0] sel;
   logic [3:0]       sh;
   logic [CNT_W-1:0] scaled;

   always_comb begin
      mult   = tbyte[VAL_W-1:0];
      sel    = tbyte[DATA_W-1:VAL_W];
      sh     = pres_shift(sel);
      scaled = CNT_W'(mult) << sh;
      len    = scaled + CNT_W'(1);
   end

endmodule

// File: rtl/cct_seq.sv
module cct_seq
   import cct_pkg::*;
#(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_write,
   input  logic [CNT_W-1:0] len_setup,
   input  logic [CNT_W-1:0] len_cmd,
   input  logic [CNT_W-1:0] len_rec,
   output logic             busy,
   output logic             cmd_n,
   output logic             done,
   output logic             cyc_write
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   phase_t           phase;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cmd_len_q;
   logic [CNT_W-1:0] rec_len_q;
   logic             wr_q;
   logic             last;

   assign last = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         cmd_len_q <= '0;
         rec_len_q <= '0;
         wr_q      <= 1'b0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase     <= PH_SETUP;
                  cnt       <= len_setup - ONE;
                  cmd_len_q <= len_cmd;
                  rec_len_q <= len_rec;
                  wr_q      <= start_write;
               end
            end
            PH_SETUP: begin
               if (last) begin
                  phase <= PH_CMD;
                  cnt   <= cmd_len_q - ONE;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            PH_CMD: begin
               if (last) begin
                  phase <= PH_REC;
                  cnt   <= rec_len_q - ONE;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            default: begin
               if (last)
                  phase <= PH_IDLE;
               else
                  cnt <= cnt - ONE;
            end
         endcase
      end
   end

   assign busy      = (phase != PH_IDLE);
   assign cmd_n     = (phase != PH_CMD);
   assign done      = (phase == PH_REC) && last;
   assign cyc_write = wr_q;

   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy) else $error("start not taken"); // R9

   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy) else $error("busy after done"); // R8

   AST_STROBE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_n |-> busy) else $error("strobe while idle"); // R7

   AST_CMD_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_n) |-> ($past(phase) == PH_SETUP)) else $error("order"); // R7

   AST_REC_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_n) |-> (phase == PH_REC)) else $error("order"); // R7

   AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && $stable(cyc_write))) else $error("cycle cut"); // R11

endmodule

// File: rtl/card_cycle_timer.sv
module card_cycle_timer
   import cct_pkg::*;
#(
   parameter int               ADDR_W    = 8,
   parameter int               VAL_W     = 6,
   parameter int               SEL_W     = 2,
   parameter logic [ADDR_W-1:0] BASE_IDX = 8'h3A,
   parameter logic [7:0]       DEF_SETUP = 8'h01,
   parameter logic [7:0]       DEF_CMD   = 8'h06,
   parameter logic [7:0]       DEF_REC   = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_write,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic              busy,
   output logic              cmd_n,
   output logic              done,
   output logic              cyc_write
);

   localparam int DATA_W = VAL_W + SEL_W;
   localparam int CNT_W  = VAL_W + MAX_SHIFT;
   localparam logic [NUM_PHASES*8-1:0] DEFS = {DEF_REC, DEF_CMD, DEF_SETUP};

   initial begin
      assert (DATA_W == 8) else $error("timing byte must be 8 bits wide");
      assert (SEL_W == 2) else $error("prescaler code must be 2 bits");
      assert (VAL_W >= 1) else $error("multiplier field empty");
   end

   logic [NUM_PHASES*DATA_W-1:0] regs_flat;
   logic [CNT_W-1:0]             lens [NUM_PHASES];

   cct_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_PHASES),
      .BASE_IDX (BASE_IDX),
      .DEFAULTS (DEFS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .regs_flat (regs_flat)
   );

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_len
      cct_len_calc #(
         .VAL_W (VAL_W),
         .SEL_W (SEL_W),
         .CNT_W (CNT_W)
      ) u_len (
         .tbyte (regs_flat[p*DATA_W +: DATA_W]),
         .len   (lens[p])
      );
   end

   cct_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_write (start_write),
      .len_setup   (lens[0]),
      .len_cmd     (lens[1]),
      .len_rec     (lens[2]),
      .busy        (busy),
      .cmd_n       (cmd_n),
      .done        (done),
      .cyc_write   (cyc_write)
   );

endmodule

// File: tb/tb_card_cycle_timer.sv
module tb_card_cycle_timer;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      int s;
      int c;
      int r;
      bit wr;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       start_write = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       busy, cmd_n, done, cyc_write;

   int   total = 0;
   int   bad = 0;
   exp_t q[$];
   logic [7:0] sh [3];
   int   last_s, last_c, last_r;

   always #(CLK_PERIOD/2) clk = ~clk;

   card_cycle_timer dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .busy(busy), .cmd_n(cmd_n), .done(done), .cyc_write(cyc_write)
   );

   function automatic int blen(input logic [7:0] b);
      int p;
      case (b[7:6])
         2'b00: p = 1;
         2'b01: p = 16;
         2'b10: p = 64;
         default: p = 256;
      endcase
      return p * int'(b[5:0]) + 1;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      if (a >= 8'h3A && a <= 8'h3C) sh[a - 8'h3A] = d;
   endtask

   // driver: pushes the expected access, then requests it
   task automatic fire(input bit wr);
      exp_t e;
      @(negedge clk);
      e.s = blen(sh[0]); e.c = blen(sh[1]); e.r = blen(sh[2]); e.wr = wr;
      q.push_back(e);
      start = 1'b1; start_write = wr;
      @(negedge clk);
      check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: measures each access and compares with the queued item
   bit   in_seg = 0, seen_done = 0, have_exp = 0;
   int   ms, mc, mr;
   exp_t cur;
   always @(negedge clk) begin
      if (rst_n) begin
         if (seen_done) check(busy == 1'b0, "R8 busy drops after done", int'(busy), 0);
         seen_done = 0;
         if (busy) begin
            if (!in_seg) begin
               in_seg = 1; ms = 0; mc = 0; mr = 0;
               if (q.size() == 0) begin
                  have_exp = 0;
                  check(1'b0, "R9 unexpected access started", 1, 0);
               end else begin
                  cur = q.pop_front(); have_exp = 1;
                  check(cyc_write == cur.wr, "R11 direction", int'(cyc_write), int'(cur.wr));
               end
            end
            if (!cmd_n) begin
               if (mr > 0) check(1'b0, "R7 strobe fell again", mr, 0);
               mc++;
            end else if (mc == 0) ms++;
            else mr++;
            if (done) begin
               seen_done = 1; in_seg = 0;
               last_s = ms; last_c = mc; last_r = mr;
               if (have_exp) begin
                  check(ms == cur.s, "R1 setup length", ms, cur.s);
                  check(mc == cur.c, "R2 command length", mc, cur.c);
                  check(mr == cur.r, "R3 recovery length", mr, cur.r);
                  check(cyc_write == cur.wr, "R11 direction at end", int'(cyc_write), int'(cur.wr));
               end
            end
         end else begin
            if (in_seg) begin
               check(1'b0, "R8 access ended without done", 0, 1);
               in_seg = 0;
            end
            if (done) check(1'b0, "R8 done while idle", 1, 0);
            if (!cmd_n) check(1'b0, "R7 strobe while idle", 0, 1);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      sh[0] = 8'h01; sh[1] = 8'h06; sh[2] = 8'h03;
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R6 reset busy", int'(busy), 0);
      check(cmd_n == 1'b1, "R6 reset strobe", int'(cmd_n), 1);
      check(done == 1'b0, "R6 reset done", int'(done), 0);
      rst_n = 1'b1;

      // defaults after reset
      fire(1'b0); wait_idle();
      check(last_s == 2, "R6 default setup", last_s, 2);
      check(last_c == 7, "R6 default command", last_c, 7);
      check(last_r == 4, "R6 default recovery", last_r, 4);

      // prescaler codes 01, 10, 11
      wr_reg(8'h3A, 8'h43); wr_reg(8'h3B, 8'h80); wr_reg(8'h3C, 8'hC1);
      fire(1'b1); wait_idle();
      check(last_s == 49, "R4 x16 code", last_s, 49);
      check(last_c == 1, "R4 zero multiplier", last_c, 1);
      check(last_r == 257, "R4 x256 code", last_r, 257);

      // x1 and x64 with full multiplier
      wr_reg(8'h3A, 8'h00); wr_reg(8'h3B, 8'hBF); wr_reg(8'h3C, 8'h02);
      fire(1'b0); wait_idle();
      check(last_c == 64*63+1, "R4 x64 full multiplier", last_c, 64*63+1);

      // writes to neighbouring indices are ignored
      wr_reg(8'h3D, 8'hFF); wr_reg(8'h39, 8'hFF);
      fire(1'b1); wait_idle();
      check(last_s == 1 && last_c == 4033 && last_r == 3, "R5 stray index", last_s, 1);

      // held start: three accesses, each separated by an idle clock
      wr_reg(8'h3A, 8'h00); wr_reg(8'h3B, 8'h01); wr_reg(8'h3C, 8'h00);
      for (int k = 0; k < 3; k++) begin
         exp_t e;
         e.s = 1; e.c = 2; e.r = 1; e.wr = 1'b1;
         q.push_back(e);
      end
      @(negedge clk);
      start = 1'b1; start_write = 1'b1;
      n = 0;
      while (n < 3) begin
         @(negedge clk);
         if (done) n++;
      end
      start = 1'b0;
      wait_idle();
      check(q.size() == 0, "R9 held start accesses", q.size(), 0);

      // start pulses during an access are ignored
      wr_reg(8'h3A, 8'h05); wr_reg(8'h3B, 8'h05); wr_reg(8'h3C, 8'h05);
      fire(1'b0);
      repeat (4) @(negedge clk);
      start = 1'b1; start_write = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R9 mid-access start ignored", int'(busy), 0);
      check(last_s == 6, "R9 access length unchanged", last_s, 6);

      // writes during an access apply only to the next access
      wr_reg(8'h3A, 8'h01); wr_reg(8'h3B, 8'h02); wr_reg(8'h3C, 8'h01);
      fire(1'b0);
      wr_reg(8'h3B, 8'h05);
      wr_reg(8'h3C, 8'h04);
      wait_idle();
      check(last_c == 3, "R10 current access keeps old command", last_c, 3);
      check(last_r == 2, "R10 current access keeps old recovery", last_r, 2);
      fire(1'b1); wait_idle();
      check(last_c == 6, "R10 next access uses new command", last_c, 6);

      // longest recovery
      wr_reg(8'h3C, 8'hFF);
      fire(1'b0); wait_idle();
      check(last_r == 16129, "R4 x256 full multiplier", last_r, 16129);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule